// File: doc/BRIEF.md
# Frame-configurable UART transmitter

This block serialises characters onto an asynchronous transmit line. Characters enter through a valid/ready stream port and wait in a two-entry holding buffer. A shift engine takes them one at a time and sends each as a frame. A frame is a low start bit, then the data bits least significant first, then an optional parity bit, then a high stop period. Every bit lasts sixteen pulses of an oversample tick, and the tick comes from a baud generator outside the block.

A 16-bit frame word on plain input pins sets the data width, the parity mode and the stop length. The block reads this word when a frame begins, so a frame in flight is never altered. Software turns the transmitter on and off with two single-cycle command pulses. Turning it off lets the current frame finish and then keeps the line high. Characters may still enter the buffer while the transmitter is off.

The status vector reports three bits:
- whether the transmitter is enabled;
- whether the buffer has room, with a trigger level that can be selected;
- whether everything has been sent.

Two sticky interrupt flags record when the room and complete conditions start, and a write-one-to-clear input resets them.

Back-pressure on the stream: a character is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low exactly when the buffer holds two characters. While `in_ready` is low, the presented character is not taken and the buffer does not change. The source may keep or withdraw `in_valid` freely. Accepted characters leave in the order they arrived.

Top module: `frame_uart_tx`

## Requirements
- R1: After reset the line `txd` is high, `in_ready` is 1, `irq_flags` is 0 and `status` is 8'h40: enabled bit1 = 0, complete bit5 = 0, room bit6 = 1.
- R2: A `cmd_en` pulse sets status bit1 on the next clock edge and a `cmd_dis` pulse clears it. When both arrive in the same cycle, disable wins.
- R3: A frame is a low start bit, then data LSB first, then the parity bit if enabled, then the stop period. Each start, data and parity bit lasts 16 `baud_tick` pulses, and the line is high whenever no frame is in progress.
- R4: `frame_cfg[3:0]` holds the data width minus 3. Values 2..5 give 5..8 bits, values below 2 give 5 bits, and values above 5 give 8 bits.
- R5: `frame_cfg[9:8]` selects parity. 2'b10 is even, so the data plus parity bit hold an even number of ones. 2'b11 is odd. 2'b00 and 2'b01 mean no parity bit.
- R6: `frame_cfg[13:12]` selects the stop length. 2'b00 gives 8 ticks (half a bit), 2'b01 and 2'b10 give 16 ticks, and 2'b11 gives 32 ticks.
- R7: The buffer holds two characters, and `in_ready` is low only when it is full. A character presented while `in_ready` is low is not sent.
- R8: With `trig_half` = 1, status bit6 is high while the buffer holds at most one character. With `trig_half` = 0, it is high only while the buffer is empty.
- R9: Status bit5 rises when a frame's stop period ends with the buffer empty. It clears when a character is accepted, and a frame cut short by a disable does not set it.
- R10: `irq_flags[0]` is set when status bit5 rises and `irq_flags[1]` is set when status bit6 rises. Writing a 1 to the matching `flag_clr` bit clears a flag, but a new rise in the same cycle wins over the clear.
- R11: A disable during a frame lets that frame finish. The line then stays high and queued characters wait until the next enable. The frame word is read only when a frame starts.
- R12: When a character is waiting and the transmitter is enabled, the next start bit follows the end of the stop period with no tick in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | Oversample tick, 16 per bit |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Buffer has space |
| in_data | input | 8 | Character; bits above the data width are not sent |
| cmd_en | input | 1 | Enable pulse |
| cmd_dis | input | 1 | Disable pulse |
| frame_cfg | input | 16 | Width [3:0], parity [9:8], stop [13:12] |
| trig_half | input | 1 | Room trigger level select |
| flag_clr | input | 2 | Write-one-to-clear for the interrupt flags |
| txd | output | 1 | Serial line |
| status | output | 8 | bit1 enabled, bit5 complete, bit6 room |
| irq_flags | output | 2 | bit0 complete, bit1 room |

## Verification
The hardest state to reach from the ports is a disable that lands in the middle of a frame while a second character sits in the buffer. The frame in flight must finish intact, and the waiting character must stay put with the complete bit still low. The bench enables the transmitter and pushes two characters back to back. It then watches the line until the decoded frame is more than a bit deep, and only then pulses the disable. A second corner is the half-bit stop: the bench queues two characters while the transmitter is disabled and then enables it. That makes the frames run back to back, so any error in stop length shows up as a shifted next start bit.

// File: rtl/frame_uart_tx_pkg.sv
package frame_uart_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } tx_state_e;

  // Field codes inside the frame word.
  localparam logic [1:0] PAR_CODE_EVEN = 2'b10;
  localparam logic [1:0] PAR_CODE_ODD  = 2'b11;
  localparam logic [1:0] STOP_CODE_HALF = 2'b00;
  localparam logic [1:0] STOP_CODE_TWO  = 2'b11;

  // Narrowest data width the frame word can ask for.
  localparam int MIN_BITS = 5;

endpackage

// File: rtl/frame_uart_tx_buf.sv
module frame_uart_tx_buf #(
  parameter int W     = 8,
  parameter int DEPTH = 2,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     dout,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             do_push, do_pop;

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_pop)  rd_ptr <= nxt(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/frame_uart_tx_ser.sv
module frame_uart_tx_ser
  import frame_uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16,
  localparam int TCW = $clog2(2 * OVS),
  localparam int BCW = $clog2(DATA_W + 1),
  localparam int SCW = $clog2(2 * OVS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              ld,
  input  logic [DATA_W-1:0] ld_data,
  input  logic [BCW-1:0]    ld_nbits,
  input  logic              ld_par_en,
  input  logic              ld_par_bit,
  input  logic [SCW-1:0]    ld_stop_ticks,
  output logic              busy,
  output logic              done,
  output logic              txd
);

  tx_state_e         state;
  logic [TCW-1:0]    tcnt;
  logic [BCW-1:0]    bidx;
  logic [BCW-1:0]    nbits;
  logic [DATA_W-1:0] shreg;
  logic              par_en, par_bit;
  logic [TCW-1:0]    stop_lim;
  logic              bit_last;

  assign bit_last = (tcnt == TCW'(OVS - 1));
  assign busy     = (state != ST_IDLE);

  always_comb begin
    case (state)
      ST_START: txd = 1'b0;
      ST_DATA:  txd = shreg[0];
      ST_PAR:   txd = par_bit;
      default:  txd = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      tcnt     <= '0;
      bidx     <= '0;
      nbits    <= '0;
      shreg    <= '0;
      par_en   <= 1'b0;
      par_bit  <= 1'b0;
      stop_lim <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (ld) begin
            state    <= ST_START;
            tcnt     <= '0;
            bidx     <= '0;
            nbits    <= ld_nbits;
            shreg    <= ld_data;
            par_en   <= ld_par_en;
            par_bit  <= ld_par_bit;
            stop_lim <= TCW'(ld_stop_ticks - 1'b1);
          end
        end
        ST_START: begin
          if (tick) begin
            if (bit_last) begin
              tcnt  <= '0;
              state <= ST_DATA;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
        end
        ST_DATA: begin
          if (tick) begin
            if (bit_last) begin
              tcnt  <= '0;
              shreg <= shreg >> 1;
              if (bidx == nbits - 1'b1) state <= par_en ? ST_PAR : ST_STOP;
              else                      bidx  <= bidx + 1'b1;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
        end
        ST_PAR: begin
          if (tick) begin
            if (bit_last) begin
              tcnt  <= '0;
              state <= ST_STOP;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
        end
        ST_STOP: begin
          if (tick) begin
            if (tcnt == stop_lim) begin
              tcnt  <= '0;
              state <= ST_IDLE;
              done  <= 1'b1;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/frame_uart_tx_ctl.sv
module frame_uart_tx_ctl #(
  parameter int DEPTH = 2,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_en,
  input  logic             cmd_dis,
  input  logic             push_acc,
  input  logic             frame_done,
  input  logic [CNT_W-1:0] buf_count,
  input  logic             trig_half,
  input  logic [1:0]       flag_clr,
  output logic             tx_en,
  output logic             txc,
  output logic             txbl,
  output logic [1:0]       flags
);

  logic txbl_q;
  logic txc_set;

  assign txbl = trig_half ? (buf_count <= CNT_W'(DEPTH / 2)) : (buf_count == '0);
  assign txc_set = frame_done && (buf_count == '0) && !push_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en  <= 1'b0;
      txc    <= 1'b0;
      txbl_q <= 1'b1;
      flags  <= 2'b00;
    end else begin
      if (cmd_dis)     tx_en <= 1'b0;
      else if (cmd_en) tx_en <= 1'b1;

      if (push_acc)     txc <= 1'b0;
      else if (txc_set) txc <= 1'b1;

      txbl_q   <= txbl;
      flags[0] <= (flags[0] && !flag_clr[0]) || (txc_set && !txc);
      flags[1] <= (flags[1] && !flag_clr[1]) || (txbl && !txbl_q);
    end
  end

endmodule

// File: rtl/frame_uart_tx.sv
module frame_uart_tx
  import frame_uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              cmd_en,
  input  logic              cmd_dis,
  input  logic [15:0]       frame_cfg,
  input  logic              trig_half,
  input  logic [1:0]        flag_clr,
  output logic              txd,
  output logic [7:0]        status,
  output logic [1:0]        irq_flags
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int BCW   = $clog2(DATA_W + 1);
  localparam int SCW   = $clog2(2 * OVS + 1);

  logic [DATA_W-1:0] buf_dout;
  logic [CNT_W-1:0]  buf_count;
  logic              buf_full, buf_empty;
  logic              push_acc, ser_ld, ser_busy, ser_done;
  logic              tx_en, txc, txbl;
  logic [BCW-1:0]    nbits_sel;
  logic [DATA_W-1:0] data_mask;
  logic              par_en_sel, par_bit_sel;
  logic [SCW-1:0]    stop_sel;
  logic              unused_cfg;

  assign unused_cfg = ^{frame_cfg[15:14], frame_cfg[11:10], frame_cfg[7:4]};

  assign in_ready = !buf_full;
  assign push_acc = in_valid && in_ready;
  assign ser_ld   = !ser_busy && tx_en && !buf_empty;

  // Width decode with clamping to the supported range.
  always_comb begin
    if (frame_cfg[3:0] < 4'(MIN_BITS - 3))      nbits_sel = BCW'(MIN_BITS);
    else if (frame_cfg[3:0] > 4'(DATA_W - 3))   nbits_sel = BCW'(DATA_W);
    else                                        nbits_sel = BCW'(frame_cfg[3:0] + 4'd3);
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign data_mask[i] = (i < int'(nbits_sel));
  end

  assign par_en_sel  = (frame_cfg[9:8] == PAR_CODE_EVEN) || (frame_cfg[9:8] == PAR_CODE_ODD);
  assign par_bit_sel = (^(buf_dout & data_mask)) ^ (frame_cfg[9:8] == PAR_CODE_ODD);

  always_comb begin
    case (frame_cfg[13:12])
      STOP_CODE_HALF: stop_sel = SCW'(OVS / 2);
      STOP_CODE_TWO:  stop_sel = SCW'(2 * OVS);
      default:        stop_sel = SCW'(OVS);
    endcase
  end

  frame_uart_tx_buf #(.W(DATA_W), .DEPTH(DEPTH)) u_buf (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push_acc),
    .din   (in_data),
    .pop   (ser_ld),
    .dout  (buf_dout),
    .count (buf_count),
    .full  (buf_full),
    .empty (buf_empty)
  );

  frame_uart_tx_ser #(.DATA_W(DATA_W), .OVS(OVS)) u_ser (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick          (baud_tick),
    .ld            (ser_ld),
    .ld_data       (buf_dout),
    .ld_nbits      (nbits_sel),
    .ld_par_en     (par_en_sel),
    .ld_par_bit    (par_bit_sel),
    .ld_stop_ticks (stop_sel),
    .busy          (ser_busy),
    .done          (ser_done),
    .txd           (txd)
  );

  frame_uart_tx_ctl #(.DEPTH(DEPTH)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_en     (cmd_en),
    .cmd_dis    (cmd_dis),
    .push_acc   (push_acc),
    .frame_done (ser_done),
    .buf_count  (buf_count),
    .trig_half  (trig_half),
    .flag_clr   (flag_clr),
    .tx_en      (tx_en),
    .txc        (txc),
    .txbl       (txbl),
    .flags      (irq_flags)
  );

  assign status = {1'b0, txbl, txc, 3'b000, tx_en, 1'b0};

endmodule

// File: rtl/frame_uart_tx_chk.sv
module frame_uart_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       txd,
  input logic       busy,
  input logic       buf_full,
  input logic       buf_empty,
  input logic       in_ready,
  input logic [7:0] status,
  input logic       cmd_en,
  input logic       cmd_dis
);

  // R3: line high whenever no frame is in progress
  a_r3_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);

  // R3: a new frame opens with a low start bit
  a_r3_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd);

  // R7: a full buffer refuses characters
  a_r7_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    buf_full |-> !in_ready);

  // R8: a full buffer never reports room
  a_r8_full_no_room: assert property (@(posedge clk) disable iff (!rst_n)
    buf_full |-> !status[6]);

  // R9: complete means idle line and empty buffer
  a_r9_complete_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    status[5] |-> (txd && buf_empty && !busy));

  // R2: enable and disable commands
  a_r2_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_en && !cmd_dis) |=> status[1]);
  a_r2_disable: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_dis |=> !status[1]);

  // R11: no new frame starts while disabled
  a_r11_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!status[1] && !busy) |=> !busy);

endmodule

bind frame_uart_tx frame_uart_tx_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .txd       (txd),
  .busy      (ser_busy),
  .buf_full  (buf_full),
  .buf_empty (buf_empty),
  .in_ready  (in_ready),
  .status    (status),
  .cmd_en    (cmd_en),
  .cmd_dis   (cmd_dis)
);

// File: tb/frame_uart_tx_bench.sv
module frame_uart_tx_bench;

  localparam int TICK_DIV = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       baud_tick;
  logic       in_valid;
  logic       in_ready;
  logic [7:0] in_data;
  logic       cmd_en, cmd_dis;
  logic [15:0] frame_cfg;
  logic       trig_half;
  logic [1:0] flag_clr;
  logic       txd;
  logic [7:0] status;
  logic [1:0] irq_flags;

  always #4 clk = ~clk;

  frame_uart_tx u_frame_uart_tx (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .cmd_en(cmd_en), .cmd_dis(cmd_dis), .frame_cfg(frame_cfg),
    .trig_half(trig_half), .flag_clr(flag_clr),
    .txd(txd), .status(status), .irq_flags(irq_flags)
  );

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Bench model of the current frame format
  int cur_w, cur_p, cur_stop, cur_nbits, cur_total;

  function automatic logic [11:0] exp_bits(input logic [7:0] d, input int w, input int p);
    logic [11:0] v = '0;
    logic x = 1'b0;
    for (int i = 0; i < w; i++) begin
      v[1 + i] = d[i];
      x ^= d[i];
    end
    if (p == 2) v[1 + w] = x;
    if (p == 3) v[1 + w] = ~x;
    return v;
  endfunction

  task automatic set_cfg(input int wf, input int par, input int stp);
    frame_cfg = {2'b00, 2'(stp), 2'b00, 2'(par), 4'b0000, 4'(wf)};
    cur_w = wf + 3;
    if (cur_w < 5) cur_w = 5;
    if (cur_w > 8) cur_w = 8;
    cur_p = (par >= 2) ? par : 0;
    cur_stop = (stp == 0) ? 8 : (stp == 3) ? 32 : 16;
    cur_nbits = 1 + cur_w + ((cur_p != 0) ? 1 : 0);
    cur_total = 16 * cur_nbits + cur_stop;
  endtask

  // Line monitor and tick generator
  logic [11:0] exp_mem [64];
  logic [11:0] cap_mem [64];
  bit          bad_mem [64];
  int          gap_mem [64];
  int exp_n = 0, cap_n = 0;
  bit in_frame = 0;
  int tcount = 0, gap = 0, gap_rec = 0, div = 0;
  logic [11:0] cap;
  bit stop_bad;
  logic txd_q = 1'b1;

  always @(negedge clk) begin
    if (!rst_n) begin
      in_frame = 0; gap = 0; txd_q = 1'b1; baud_tick = 1'b0; div = 0;
    end else begin
      if (in_frame && baud_tick) begin
        tcount++;
        if (tcount % 16 == 8) begin
          if (tcount / 16 < cur_nbits) cap[tcount / 16] = txd;
          else if (!txd) stop_bad = 1;
        end
        if (tcount == cur_total) begin
          if (!txd) stop_bad = 1;
          if (cap_n < 64) begin
            cap_mem[cap_n] = cap; bad_mem[cap_n] = stop_bad; gap_mem[cap_n] = gap_rec;
          end
          cap_n++;
          in_frame = 0;
          gap = 0;
        end
      end else if (!in_frame && baud_tick) begin
        gap++;
      end
      if (!in_frame && txd_q && !txd) begin
        in_frame = 1; tcount = 0; cap = '0; stop_bad = 0; gap_rec = gap;
      end
      txd_q = txd;
      if (div == TICK_DIV - 1) begin div = 0; baud_tick = 1'b1; end
      else begin div++; baud_tick = 1'b0; end
    end
  end

  task automatic push_try(input logic [7:0] d, output bit acc);
    @(negedge clk);
    in_valid = 1'b1; in_data = d;
    #1 acc = in_ready;
    @(negedge clk);
    in_valid = 1'b0;
    if (acc && exp_n < 64) exp_mem[exp_n] = exp_bits(d, cur_w, cur_p);
    if (acc) exp_n++;
  endtask

  task automatic push_wait(input logic [7:0] d);
    bit acc = 0;
    int t = 0;
    while (!acc && t < 5000) begin
      push_try(d, acc);
      t++;
    end
  endtask

  task automatic pulse_cmd(input bit en, input bit dis);
    @(negedge clk);
    cmd_en = en; cmd_dis = dis;
    @(negedge clk);
    cmd_en = 1'b0; cmd_dis = 1'b0;
  endtask

  task automatic wait_idle(input string tag);
    int t = 0;
    while (!(status[5] && !in_frame) && t < 20000) begin
      @(negedge clk);
      t++;
    end
    if (t >= 20000) check({tag, " timeout waiting for complete"}, 0, 1);
    repeat (4) @(negedge clk);
  endtask

  task automatic compare_frames(input string tag);
    check({tag, " R7 frame count"}, cap_n, exp_n);
    for (int i = 0; i < cap_n && i < exp_n && i < 64; i++) begin
      check({tag, " R3 R4 R5 frame bits"}, int'(cap_mem[i]), int'(exp_mem[i]));
      check({tag, " R6 stop high"}, int'(bad_mem[i]), 0);
    end
  endtask

  task automatic clear_log();
    exp_n = 0; cap_n = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    bit acc;
    void'($urandom(32'h1F2E3D4C));
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; cmd_en = 1'b0; cmd_dis = 1'b0;
    trig_half = 1'b0; flag_clr = 2'b00;
    set_cfg(5, 0, 1);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 txd", txd, 1);
    check("R1 status", status, 8'h40);
    check("R1 flags", irq_flags, 0);
    check("R1 ready", in_ready, 1);

    // R2 commands
    pulse_cmd(1, 0);
    check("R2 enable", status[1], 1);
    pulse_cmd(1, 1);
    check("R2 disable wins", status[1], 0);

    // R8 / R7 buffer levels while disabled
    push_wait(8'hA5);
    check("R8 one entry, full-empty trigger", status[6], 0);
    trig_half = 1'b1;
    #1 check("R8 one entry, half trigger", status[6], 1);
    push_wait(8'h3C);
    check("R7 ready low when full", in_ready, 0);
    check("R8 full, half trigger", status[6], 0);
    push_try(8'hFF, acc);
    check("R7 full push ignored", acc, 0);
    check("R9 complete low with data waiting", status[5], 0);
    pulse_cmd(1, 0);
    wait_idle("R7 directed");
    compare_frames("R7 directed");
    check("R12 back-to-back gap", gap_mem[1], 0);
    check("R9 complete after drain", status[5], 1);
    check("R10 flags after drain", irq_flags, 3);
    clear_log();

    // R10 flag clearing
    @(negedge clk); flag_clr = 2'b01;
    @(negedge clk); flag_clr = 2'b00;
    check("R10 clear complete flag", irq_flags, 2);
    @(negedge clk); flag_clr = 2'b10;
    @(negedge clk); flag_clr = 2'b00;
    check("R10 clear room flag", irq_flags, 0);

    // R11 disable in mid-frame
    set_cfg(5, 2, 1);
    push_wait(8'h5A);
    push_wait(8'hC3);
    while (!(in_frame && tcount >= 20)) @(negedge clk);
    pulse_cmd(0, 1);
    repeat (2 * cur_total * TICK_DIV + 50) @(negedge clk);
    check("R11 only the frame in flight", cap_n, 1);
    check("R11 line idle", txd, 1);
    check("R11 complete stays low", status[5], 0);
    check("R11 disabled", status[1], 0);
    pulse_cmd(1, 0);
    wait_idle("R11");
    compare_frames("R11");
    clear_log();

    // R6 half stop back to back, R5 even parity
    pulse_cmd(0, 1);
    set_cfg(4, 2, 0);
    push_wait(8'h6B);
    push_wait(8'h14);
    pulse_cmd(1, 0);
    wait_idle("R6 half stop");
    compare_frames("R6 half stop");
    check("R6 R12 half stop gap", gap_mem[1], 0);
    clear_log();

    // R6 two stop bits back to back, R5 odd parity
    pulse_cmd(0, 1);
    set_cfg(3, 3, 3);
    push_wait(8'h0F);
    push_wait(8'h21);
    pulse_cmd(1, 0);
    wait_idle("R6 two stop");
    compare_frames("R6 two stop");
    check("R6 R12 two stop gap", gap_mem[1], 0);
    clear_log();

    // R4 clamping of the width field
    set_cfg(0, 0, 1);
    push_wait(8'hEE);
    wait_idle("R4 low clamp");
    compare_frames("R4 low clamp");
    clear_log();
    set_cfg(12, 3, 2);
    push_wait(8'h96);
    wait_idle("R4 high clamp");
    compare_frames("R4 high clamp");
    clear_log();

    // Random groups
    for (int g = 0; g < 24; g++) begin
      int n;
      set_cfg(2 + int'($urandom % 4), int'($urandom % 4), int'($urandom % 4));
      trig_half = 1'($urandom % 2);
      n = 1 + int'($urandom % 3);
      for (int k = 0; k < n; k++) begin
        repeat (int'($urandom % 5)) @(negedge clk);
        push_wait(8'($urandom));
      end
      wait_idle("R3 random");
      compare_frames("R3 random");
      clear_log();
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule